// File: doc/BRIEF.md
# IQ Correction Coefficient Register Bank

This block is the register slave that sits between a peripheral bus (APB-style, with a ready that is always high) and a 2×2 IQ correction datapath. Firmware reaches it through one control word, one status word, four staged coefficient words and a commit word. The datapath reads the enable and mode fields and the four active coefficients directly from registered outputs. It reports lock state and saturation events back to this block.

Coefficients are staged. A bus write only changes a shadow copy. A write to the commit word arms a transfer. On the next symbol-boundary strobe, all four shadow values move into the active registers on the same clock edge, so the datapath never runs with a mix of old and new values. The status word holds only status: a live lock bit and a sticky saturation bit that is cleared by writing 1. Firmware can therefore read-modify-write the control word without racing the hardware.

Top module: `iqcal_regbank`

## Requirements
- R1: After synchronous reset, `dp_enable` is 0 and `dp_mode` is 0. The active and shadow coefficients hold the identity matrix: C11 = C22 = 0x4000 (1.0 in signed Q2.14) and C12 = C21 = 0. The saturation flag is clear.
- R2: The control word is at offset 0x00 and is read/write. Bit 0 is the enable and bits 2:1 are the mode. These drive `dp_enable` and `dp_mode` from the clock edge of the write. Bits above 2 are dropped on write and read as 0.
- R3: The shadow coefficients are at 0x10 (C11), 0x14 (C12), 0x18 (C21) and 0x1C (C22). Each keeps the low 16 bits of the written data and reads back zero-extended. A shadow write never changes `c11`..`c22`.
- R4: A write to the commit word at 0x20 arms a transfer. At the edge that ends the first cycle after that write in which `sym_strobe` is high, all four active outputs take the shadow values together. Until that edge, the active outputs stay unchanged.
- R5: A `sym_strobe` with no armed transfer leaves the active outputs unchanged. A completed transfer disarms, so later strobes do not copy again.
- R6: The commit word is write-only and reads as 0. A second commit write while a transfer is armed keeps it armed, and only one transfer results.
- R7: Status bit 1 (saturation) is set by a `sat_evt` pulse and stays set. Writing 1 to bit 1 of the status word at 0x04 clears it. Writing 0 there leaves it unchanged.
- R8: If `sat_evt` is high in the same cycle as a clearing write, the saturation bit stays set.
- R9: Status bit 0 reads the current `lock_in` level, sampled in the setup cycle of the read. Writes to it have no effect.
- R10: Reads from any other offset (for example 0x08, 0x24, or a non-word-aligned address) return 0. Writes there change no register.
- R11: `pready` is always 1. Read data is valid in the access cycle of every read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, registered in the setup cycle |
| pready | output | 1 | Always high |
| sym_strobe | input | 1 | Symbol-boundary pulse from the datapath |
| lock_in | input | 1 | Live lock indication |
| sat_evt | input | 1 | Saturation event pulse |
| dp_enable | output | 1 | Datapath enable |
| dp_mode | output | 2 | Datapath mode |
| c11 | output | COEF_W | Active coefficient C11 |
| c12 | output | COEF_W | Active coefficient C12 |
| c21 | output | COEF_W | Active coefficient C21 |
| c22 | output | COEF_W | Active coefficient C22 |

## Verification
The properties assume well-formed bus transfers: one setup cycle with `psel` high and `penable` low, then one access cycle with the same address, direction and data. They also assume that `sym_strobe` and `sat_evt` are single-cycle pulses from the core clock domain. The bench drives every transfer through two-phase read and write tasks and changes all inputs only on the falling edge. The random phase mixes shadow writes, readbacks, commits, strobes and control writes in any order. This includes strobes with nothing armed and repeated commits, so the armed/disarmed sequencing is covered beyond the directed cases.

// File: rtl/iqcal_pkg.sv
package iqcal_pkg;

  localparam int unsigned DEF_ADDR_W = 8;
  localparam int unsigned DEF_DATA_W = 32;
  localparam int unsigned DEF_COEF_W = 16;
  localparam int unsigned N_COEF     = 4;

  // byte offsets
  localparam int unsigned OFS_CTRL   = 'h00;
  localparam int unsigned OFS_STAT   = 'h04;
  localparam int unsigned OFS_COEF0  = 'h10;
  localparam int unsigned OFS_COMMIT = 'h20;

  // field positions
  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_MODE_LSB = 1;
  localparam int unsigned CTRL_W        = 3;
  localparam int unsigned STAT_LOCK_BIT = 0;
  localparam int unsigned STAT_SAT_BIT  = 1;

  typedef enum logic [2:0] {
    RSEL_NONE,
    RSEL_CTRL,
    RSEL_STAT,
    RSEL_COEF,
    RSEL_COMMIT
  } rsel_e;

endpackage

// File: rtl/iqcal_addr_dec.sv
module iqcal_addr_dec
  import iqcal_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned NC     = N_COEF,
  localparam int unsigned IDX_W = $clog2(NC)
) (
  input  logic [ADDR_W-1:0] addr,
  output rsel_e             sel,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_COEF0  = ADDR_W'(OFS_COEF0);
  localparam logic [ADDR_W-1:0] A_COEFN  = ADDR_W'(OFS_COEF0 + 4 * NC);
  localparam logic [ADDR_W-1:0] A_COMMIT = ADDR_W'(OFS_COMMIT);

  logic [ADDR_W-1:0] off;
  assign off = addr - A_COEF0;
  assign idx = IDX_W'(off >> 2);

  always_comb begin
    sel = RSEL_NONE;
    if (addr == A_CTRL)
      sel = RSEL_CTRL;
    else if (addr == A_STAT)
      sel = RSEL_STAT;
    else if (addr >= A_COEF0 && addr < A_COEFN && addr[1:0] == 2'b00)
      sel = RSEL_COEF;
    else if (addr == A_COMMIT)
      sel = RSEL_COMMIT;
  end
endmodule

// File: rtl/iqcal_coef_bank.sv
module iqcal_coef_bank #(
  parameter int unsigned           COEF_W  = 16,
  parameter int unsigned           NC      = 4,
  parameter logic [NC*COEF_W-1:0]  RST_VAL = '0,
  localparam int unsigned          IDX_W   = $clog2(NC)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [COEF_W-1:0]      wr_data,
  input  logic                   commit_wr,
  input  logic                   sym_strobe,
  output logic [NC*COEF_W-1:0]   shadow_vec,
  output logic [NC*COEF_W-1:0]   active_vec,
  output logic                   pending
);
  logic xfer;
  assign xfer = pending & sym_strobe;

  always_ff @(posedge clk) begin
    if (rst)            pending <= 1'b0;
    else if (commit_wr) pending <= 1'b1;
    else if (xfer)      pending <= 1'b0;
  end

  for (genvar i = 0; i < NC; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        shadow_vec[i*COEF_W +: COEF_W] <= RST_VAL[i*COEF_W +: COEF_W];
      else if (wr_en && wr_idx == IDX_W'(i))
        shadow_vec[i*COEF_W +: COEF_W] <= wr_data;
    end

    always_ff @(posedge clk) begin
      if (rst)
        active_vec[i*COEF_W +: COEF_W] <= RST_VAL[i*COEF_W +: COEF_W];
      else if (xfer)
        active_vec[i*COEF_W +: COEF_W] <= shadow_vec[i*COEF_W +: COEF_W];
    end
  end
endmodule

// File: rtl/iqcal_sat_status.sv
module iqcal_sat_status (
  input  logic clk,
  input  logic rst,
  input  logic sat_evt,
  input  logic clr,
  output logic sat_q
);
  always_ff @(posedge clk) begin
    if (rst) sat_q <= 1'b0;
    else     sat_q <= (sat_q & ~clr) | sat_evt;
  end
endmodule

// File: rtl/iqcal_regbank.sv
module iqcal_regbank
  import iqcal_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned COEF_W = DEF_COEF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  input  logic              sym_strobe,
  input  logic              lock_in,
  input  logic              sat_evt,
  output logic              dp_enable,
  output logic [1:0]        dp_mode,
  output logic [COEF_W-1:0] c11,
  output logic [COEF_W-1:0] c12,
  output logic [COEF_W-1:0] c21,
  output logic [COEF_W-1:0] c22
);
  localparam int unsigned IDX_W  = $clog2(N_COEF);
  localparam int unsigned VEC_W  = N_COEF * COEF_W;
  localparam logic [COEF_W-1:0] ONE  = COEF_W'(1) << (COEF_W - 2);
  localparam logic [COEF_W-1:0] ZERO = '0;
  localparam logic [VEC_W-1:0]  IDENT = {ONE, ZERO, ZERO, ONE};

  rsel_e              sel;
  logic [IDX_W-1:0]   idx;
  logic               wr_acc, rd_setup;
  logic               ctrl_wr, coef_wr, commit_wr, sat_clr;
  logic [CTRL_W-1:0]  ctrl_q;
  logic               sat_q;
  logic               commit_pend;
  logic [VEC_W-1:0]   shd_vec, act_vec;
  logic [DATA_W-1:0]  rd_next;

  assign pready   = 1'b1;
  assign wr_acc   = psel & penable & pwrite;
  assign rd_setup = psel & ~penable & ~pwrite;

  iqcal_addr_dec #(.ADDR_W(ADDR_W), .NC(N_COEF)) u_dec (
    .addr (paddr),
    .sel  (sel),
    .idx  (idx)
  );

  assign ctrl_wr   = wr_acc && sel == RSEL_CTRL;
  assign coef_wr   = wr_acc && sel == RSEL_COEF;
  assign commit_wr = wr_acc && sel == RSEL_COMMIT;
  assign sat_clr   = wr_acc && sel == RSEL_STAT && pwdata[STAT_SAT_BIT];

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= pwdata[CTRL_W-1:0];
  end

  assign dp_enable = ctrl_q[CTRL_EN_BIT];
  assign dp_mode   = ctrl_q[CTRL_MODE_LSB +: 2];

  iqcal_coef_bank #(.COEF_W(COEF_W), .NC(N_COEF), .RST_VAL(IDENT)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (coef_wr),
    .wr_idx     (idx),
    .wr_data    (pwdata[COEF_W-1:0]),
    .commit_wr  (commit_wr),
    .sym_strobe (sym_strobe),
    .shadow_vec (shd_vec),
    .active_vec (act_vec),
    .pending    (commit_pend)
  );

  assign c11 = act_vec[0*COEF_W +: COEF_W];
  assign c12 = act_vec[1*COEF_W +: COEF_W];
  assign c21 = act_vec[2*COEF_W +: COEF_W];
  assign c22 = act_vec[3*COEF_W +: COEF_W];

  iqcal_sat_status u_sat (
    .clk     (clk),
    .rst     (rst),
    .sat_evt (sat_evt),
    .clr     (sat_clr),
    .sat_q   (sat_q)
  );

  always_comb begin
    rd_next = '0;
    unique case (sel)
      RSEL_CTRL: rd_next[CTRL_W-1:0] = ctrl_q;
      RSEL_STAT: begin
        rd_next[STAT_LOCK_BIT] = lock_in;
        rd_next[STAT_SAT_BIT]  = sat_q;
      end
      RSEL_COEF: rd_next[COEF_W-1:0] = shd_vec[idx*COEF_W +: COEF_W];
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           prdata <= '0;
    else if (rd_setup) prdata <= rd_next;
  end
endmodule

// File: rtl/iqcal_regbank_chk.sv
module iqcal_regbank_chk #(
  parameter int unsigned VEC_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             pready,
  input logic             sym_strobe,
  input logic             sat_evt,
  input logic             commit_wr,
  input logic             commit_pend,
  input logic             sat_clr,
  input logic             sat_q,
  input logic             ctrl_wr,
  input logic             dp_enable,
  input logic [1:0]       dp_mode,
  input logic [VEC_W-1:0] act_vec,
  input logic [VEC_W-1:0] shd_vec
);
  p_ready_high_r11: assert property (@(posedge clk) disable iff (rst) pready);

  p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !ctrl_wr |=> $stable({dp_enable, dp_mode}));

  p_load_all_r4: assert property (@(posedge clk) disable iff (rst)
    (commit_pend && sym_strobe) |=> act_vec == $past(shd_vec));

  p_active_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !(commit_pend && sym_strobe) |=> $stable(act_vec));

  p_arm_r6: assert property (@(posedge clk) disable iff (rst)
    commit_wr |=> commit_pend);

  p_sat_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (sat_q && !sat_clr) |=> sat_q);

  p_sat_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (sat_clr && !sat_evt) |=> !sat_q);

  p_evt_wins_r8: assert property (@(posedge clk) disable iff (rst)
    sat_evt |=> sat_q);
endmodule

bind iqcal_regbank iqcal_regbank_chk #(.VEC_W(4 * COEF_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pready      (pready),
  .sym_strobe  (sym_strobe),
  .sat_evt     (sat_evt),
  .commit_wr   (commit_wr),
  .commit_pend (commit_pend),
  .sat_clr     (sat_clr),
  .sat_q       (sat_q),
  .ctrl_wr     (ctrl_wr),
  .dp_enable   (dp_enable),
  .dp_mode     (dp_mode),
  .act_vec     (act_vec),
  .shd_vec     (shd_vec)
);

// File: tb/sim_iqcal_regbank.sv
`timescale 1ns/1ps
module sim_iqcal_regbank;
  logic        clk = 1'b0;
  logic        rst;
  logic        psel, penable, pwrite;
  logic [7:0]  paddr;
  logic [31:0] pwdata;
  logic [31:0] prdata;
  logic        pready;
  logic        sym_strobe, lock_in, sat_evt;
  logic        dp_enable;
  logic [1:0]  dp_mode;
  logic [15:0] c11, c12, c21, c22;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [15:0] m_shd [4];
  logic [15:0] m_act [4];
  bit          m_pend;
  logic [2:0]  m_ctrl;

  always #2 clk = ~clk;

  iqcal_regbank u0 (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .sym_strobe(sym_strobe), .lock_in(lock_in), .sat_evt(sat_evt),
    .dp_enable(dp_enable), .dp_mode(dp_mode),
    .c11(c11), .c12(c12), .c21(c21), .c22(c22)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] act_port(input int i);
    case (i)
      0: return c11;
      1: return c12;
      2: return c21;
      default: return c22;
    endcase
  endfunction

  function automatic logic [31:0] exp_coef_read(input int i);
    return {16'h0000, m_shd[i]};
  endfunction

  task automatic chk_active(input string req);
    for (int i = 0; i < 4; i++) chk(req, {16'h0, act_port(i)}, {16'h0, m_act[i]});
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d, input bit evt = 0);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1; sat_evt = evt;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0; sat_evt = 0;
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk);
    penable = 1;
    d = prdata;
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic strobe();
    @(negedge clk); sym_strobe = 1;
    @(negedge clk); sym_strobe = 0;
    if (m_pend) begin
      for (int i = 0; i < 4; i++) m_act[i] = m_shd[i];
      m_pend = 0;
    end
  endtask

  task automatic sat_pulse();
    @(negedge clk); sat_evt = 1;
    @(negedge clk); sat_evt = 0;
  endtask

  task automatic wr_coef(input int i, input logic [31:0] d);
    apb_wr(8'h10 + 8'(4 * i), d);
    m_shd[i] = d[15:0];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'h1EC0_5EED));
    psel = 0; penable = 0; pwrite = 0; paddr = 0; pwdata = 0;
    sym_strobe = 0; lock_in = 0; sat_evt = 0; rst = 1;
    m_shd = '{16'h4000, 16'h0000, 16'h0000, 16'h4000};
    m_act = m_shd; m_pend = 0; m_ctrl = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    chk("R1 enable", {31'h0, dp_enable}, 0);
    chk("R1 mode", {30'h0, dp_mode}, 0);
    chk_active("R1 active identity");
    apb_rd(8'h10, rd); chk("R1 shadow C11", rd, 32'h4000);
    apb_rd(8'h14, rd); chk("R1 shadow C12", rd, 32'h0);
    apb_rd(8'h04, rd); chk("R1 status clear", rd, 32'h0);
    chk("R11 ready", {31'h0, pready}, 1);

    // R2 control
    apb_wr(8'h00, 32'hFFFF_FFFF);
    chk("R2 enable", {31'h0, dp_enable}, 1);
    chk("R2 mode", {30'h0, dp_mode}, 3);
    apb_rd(8'h00, rd); chk("R2 readback", rd, 32'h7);
    apb_wr(8'h00, 32'h4);
    chk("R2 enable off", {31'h0, dp_enable}, 0);
    chk("R2 mode 2", {30'h0, dp_mode}, 2);
    m_ctrl = 3'h4;

    // R3 shadow writes do not reach the datapath
    wr_coef(0, 32'hABCD_8001);
    wr_coef(1, 32'h0000_1234);
    wr_coef(2, 32'h0000_C000);
    wr_coef(3, 32'h0000_2000);
    chk_active("R3 active unchanged");
    for (int i = 0; i < 4; i++) begin
      apb_rd(8'h10 + 8'(4 * i), rd); chk("R3 shadow readback", rd, exp_coef_read(i));
    end

    // R5 strobe without commit
    strobe();
    chk_active("R5 strobe idle");

    // R4 commit then wait, then strobe
    apb_wr(8'h20, 32'h1); m_pend = 1;
    repeat (5) @(negedge clk);
    chk_active("R4 held until strobe");
    strobe();
    chk_active("R4 all four loaded");

    // R5 disarm after transfer
    wr_coef(0, 32'h0000_0777);
    strobe();
    chk_active("R5 no second copy");

    // R6 commit reads zero, double commit -> one transfer
    apb_rd(8'h20, rd); chk("R6 commit reads zero", rd, 0);
    apb_wr(8'h20, 32'hFFFF_FFFF); m_pend = 1;
    apb_wr(8'h20, 32'h1);
    strobe();
    chk_active("R6 double commit applied");
    wr_coef(3, 32'h0000_0055);
    strobe();
    chk_active("R6 single transfer");

    // R7 sticky saturation
    sat_pulse();
    apb_rd(8'h04, rd); chk("R7 sat set", rd, 32'h2);
    apb_wr(8'h04, 32'h0);
    apb_rd(8'h04, rd); chk("R7 write0 no effect", rd, 32'h2);
    apb_wr(8'h04, 32'h2);
    apb_rd(8'h04, rd); chk("R7 w1c clears", rd, 32'h0);

    // R8 event wins over clear
    sat_pulse();
    apb_wr(8'h04, 32'h2, 1);
    apb_rd(8'h04, rd); chk("R8 event wins", rd, 32'h2);
    apb_wr(8'h04, 32'h2);

    // R9 lock live and read-only
    lock_in = 1;
    apb_rd(8'h04, rd); chk("R9 lock high", rd, 32'h1);
    lock_in = 0;
    apb_wr(8'h04, 32'h1);
    apb_rd(8'h04, rd); chk("R9 lock write ignored", rd, 32'h0);

    // R10 unmapped
    apb_rd(8'h08, rd); chk("R10 read 0x08", rd, 0);
    apb_rd(8'h24, rd); chk("R10 read 0x24", rd, 0);
    apb_rd(8'h11, rd); chk("R10 read 0x11", rd, 0);
    apb_wr(8'h08, 32'hFFFF_FFFF);
    apb_wr(8'h11, 32'hFFFF_FFFF);
    apb_wr(8'h24, 32'hFFFF_FFFF);
    apb_rd(8'h00, rd); chk("R10 ctrl untouched", rd, {29'h0, m_ctrl});
    for (int i = 0; i < 4; i++) begin
      apb_rd(8'h10 + 8'(4 * i), rd); chk("R10 shadow untouched", rd, exp_coef_read(i));
    end
    strobe();
    chk_active("R10 no commit armed");

    // random phase
    for (int it = 0; it < 400; it++) begin
      int op;
      int k;
      op = int'($urandom % 5);
      k  = int'($urandom % 4);
      case (op)
        0: wr_coef(k, $urandom);
        1: begin
          apb_rd(8'h10 + 8'(4 * k), rd); chk("R3 random readback", rd, exp_coef_read(k));
        end
        2: begin apb_wr(8'h20, $urandom); m_pend = 1; end
        3: begin strobe(); chk_active("R4 random active"); end
        default: begin
          logic [31:0] d;
          d = $urandom;
          apb_wr(8'h00, d); m_ctrl = d[2:0];
          apb_rd(8'h00, rd); chk("R2 random ctrl", rd, {29'h0, m_ctrl});
        end
      endcase
    end
    chk_active("R4 final active");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule